// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex character-oriented serial link endpoint. Every cycle of `clk` counts as one oversampling tick. A bit therefore lasts 1, 16, 32 or 64 cycles, depending on the clock-factor setting. Four small configuration inputs choose the number of data bits, the stop length, the parity mode and the clock factor. The transmitter takes each setting when it accepts a byte, and the receiver takes each setting when it detects a start edge.

Bytes enter the transmitter through a valid/ready handshake and leave on `txd`. A break command drives the line to space for as long as it is held. The receiver synchronizes `rxd` and confirms the start bit at mid-bit. It assembles the character into a single holding register, which stays valid until it is taken. Parity, framing, overrun and break status travel with the character. The receiver also gives a one-cycle pulse when a break ends.

Top module: `serial_async_xcvr`

## Requirements
- R1: `cfg_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Received data is right-aligned in `rx_data`, and all unused upper bits read zero.
- R2: The line idles high. A frame is one low start bit, then the data bits LSB first, then an optional parity bit, then a high stop period. `cfg_par` selects the parity: 1 means even (the parity bit is the XOR of the data bits), 2 means odd (the inverse of that XOR), and 0 or 3 means no parity bit.
- R3: Each bit lasts F cycles, where F is 1, 16, 32 or 64 for `cfg_fac` codes 0, 1, 2 and 3.
- R4: `cfg_stop` sets the stop length. Code 0 gives F cycles. Code 1 gives F + F/2 cycles, or 2 cycles when F is 1. Codes 2 and 3 give 2F cycles.
- R5: `tx_ready` is high only when the transmitter is idle and no break is commanded. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and `txd` goes low on that edge. `tx_ready` returns exactly when the stop period ends.
- R6: While `tx_break` is high, `txd` is low from the next edge onward, and any character in flight is dropped. After release, `txd` is high and `tx_ready` is high from the next edge.
- R7: A received character sets `rx_valid`. `rx_valid`, `rx_data` and the status flags hold until `rx_take` is pulsed, and that pulse clears `rx_valid`.
- R8: When the clock factor is above 1, a low pulse that is high again by the mid-bit sample of the start bit produces no character. When F is 1, every bit is taken from a single sample per clock.
- R9: `rx_perr` is set when the received parity bit differs from the bit that the selected parity implies.
- R10: `rx_ferr` is set when the first stop bit is sampled low. If the data is not all zero, `rx_brk` stays clear.
- R11: A character with all-zero data, a zero parity bit (if present) and a low stop bit is delivered with `rx_brk` and `rx_ferr` set and `rx_perr` clear. The receiver then starts no new character until the line is high again. At that point `rx_brk_end` pulses for exactly one cycle.
- R12: If a character completes while `rx_valid` is high and no take occurs in that cycle, the held character is kept and `rx_ovr` is set. A take clears `rx_ovr`.
- R13: After reset, `txd` is high, `tx_ready` is high, `rx_valid` is low and `rx_brk_end` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | 2 | Data-bit count code (5 + code) |
| cfg_stop | input | 2 | Stop-length code |
| cfg_par | input | 2 | Parity code: 0 none, 1 even, 2 odd, 3 none |
| cfg_fac | input | 2 | Clock-factor code: 1x, 16x, 32x, 64x |
| tx_data | input | 8 | Byte to transmit (upper bits ignored for short characters) |
| tx_valid | input | 1 | Byte offered to the transmitter |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_break | input | 1 | Hold the transmit line at space |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | Holding register full |
| rx_take | input | 1 | Consume the held character |
| rx_perr | output | 1 | Parity error on held character |
| rx_ferr | output | 1 | Framing error on held character |
| rx_ovr | output | 1 | A later character was lost while this one was held |
| rx_brk | output | 1 | Held character is a break start |
| rx_brk_end | output | 1 | One-cycle pulse when the line returns to mark after a break |

## Verification
The assertions take the following for granted about the inputs:
- `tx_valid` and `tx_data` obey the usual valid/ready rules.
- `rxd` sits at mark when reset ends.
- The configuration inputs change only while neither direction is mid-character, so each latched setting matches what the driving side used.

The bench moves the configuration only between frames, after the transmitter has returned ready and the receiver's character has been taken. It drives `rxd` either from `txd` or from bench tasks that always finish a frame by returning the line high. The bench holds a break long enough for the receiver to deliver its all-zero character before the release.

// File: rtl/sax_pkg.sv
`timescale 1ns/1ps
package sax_pkg;
    localparam int DW  = 8;   // widest character
    localparam int CW  = 8;   // cycle counter, holds 2 x 64
    localparam int DBW = 4;   // bit index / bit count width
    localparam int MIN_BITS = 5;
    localparam int OS_MID = 16;
    localparam int OS_HI  = 32;
    localparam int OS_TOP = 64;

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRKW} rx_st_e;

    function automatic logic [CW-1:0] bit_cycles(input logic [1:0] fac);
        case (fac)
            2'd0:    return CW'(1);
            2'd1:    return CW'(OS_MID);
            2'd2:    return CW'(OS_HI);
            default: return CW'(OS_TOP);
        endcase
    endfunction

    function automatic logic [CW-1:0] stop_cycles(input logic [1:0] stp, input logic [1:0] fac);
        logic [CW-1:0] b;
        b = bit_cycles(fac);
        case (stp)
            2'd0:    return b;
            2'd1:    return (fac == 2'd0) ? CW'(2) : b + (b >> 1);
            default: return b << 1;
        endcase
    endfunction

    function automatic logic [DBW-1:0] data_bits(input logic [1:0] len);
        return DBW'(MIN_BITS) + {{(DBW-2){1'b0}}, len};
    endfunction

    function automatic logic [DW-1:0] data_mask(input logic [1:0] len);
        return {DW{1'b1}} >> (2'd3 - len);
    endfunction

    function automatic logic has_parity(input logic [1:0] pm);
        return (pm == PAR_EVEN) || (pm == PAR_ODD);
    endfunction
endpackage

// File: rtl/sax_tx.sv
`timescale 1ns/1ps
module sax_tx
    import sax_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_stop,
    input  logic [1:0]    cfg_par,
    input  logic [1:0]    cfg_fac,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic          tx_break,
    output logic          txd
);
    typedef struct packed {
        tx_st_e          st;
        logic [CW-1:0]   cnt;
        logic [DBW-1:0]  idx;
        logic [DW-1:0]   sh;
        logic            par;
        logic [1:0]      len;
        logic [1:0]      stp;
        logic [1:0]      pm;
        logic [1:0]      fac;
        logic            txd;
    } tx_t;

    tx_t q, d;
    logic [CW-1:0]  bitc_q, stopc_q;
    logic [DBW-1:0] nbits_q;

    always_comb begin
        d        = q;
        bitc_q   = bit_cycles(q.fac);
        stopc_q  = stop_cycles(q.stp, q.fac);
        nbits_q  = data_bits(q.len);
        tx_ready = (q.st == TX_IDLE) && !tx_break;
        if (tx_break) begin
            d.st  = TX_IDLE;
            d.txd = 1'b0;
        end else begin
            case (q.st)
                TX_IDLE: begin
                    d.txd = 1'b1;
                    if (tx_valid) begin
                        d.st  = TX_START;
                        d.txd = 1'b0;
                        d.sh  = tx_data;
                        d.len = cfg_len;
                        d.stp = cfg_stop;
                        d.pm  = cfg_par;
                        d.fac = cfg_fac;
                        d.cnt = bit_cycles(cfg_fac) - CW'(1);
                        d.par = (^(tx_data & data_mask(cfg_len))) ^ (cfg_par == PAR_ODD);
                    end
                end
                TX_START: begin
                    if (q.cnt == '0) begin
                        d.st  = TX_DATA;
                        d.txd = q.sh[0];
                        d.idx = '0;
                        d.cnt = bitc_q - CW'(1);
                    end else begin
                        d.cnt = q.cnt - CW'(1);
                    end
                end
                TX_DATA: begin
                    if (q.cnt == '0) begin
                        if (q.idx == nbits_q - DBW'(1)) begin
                            if (has_parity(q.pm)) begin
                                d.st  = TX_PAR;
                                d.txd = q.par;
                                d.cnt = bitc_q - CW'(1);
                            end else begin
                                d.st  = TX_STOP;
                                d.txd = 1'b1;
                                d.cnt = stopc_q - CW'(1);
                            end
                        end else begin
                            d.idx = q.idx + DBW'(1);
                            d.sh  = q.sh >> 1;
                            d.txd = q.sh[1];
                            d.cnt = bitc_q - CW'(1);
                        end
                    end else begin
                        d.cnt = q.cnt - CW'(1);
                    end
                end
                TX_PAR: begin
                    if (q.cnt == '0) begin
                        d.st  = TX_STOP;
                        d.txd = 1'b1;
                        d.cnt = stopc_q - CW'(1);
                    end else begin
                        d.cnt = q.cnt - CW'(1);
                    end
                end
                TX_STOP: begin
                    if (q.cnt == '0) begin
                        d.st = TX_IDLE;
                    end else begin
                        d.cnt = q.cnt - CW'(1);
                    end
                end
                default: d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd = q.txd;
endmodule

// File: rtl/sax_rx.sv
`timescale 1ns/1ps
module sax_rx
    import sax_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_par,
    input  logic [1:0]    cfg_fac,
    input  logic          rxd,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_take,
    output logic          rx_perr,
    output logic          rx_ferr,
    output logic          rx_ovr,
    output logic          rx_brk,
    output logic          rx_brk_end
);
    typedef struct packed {
        rx_st_e          st;
        logic [CW-1:0]   cnt;
        logic [DBW-1:0]  idx;
        logic [DW-1:0]   sh;
        logic            pacc;
        logic            pbit;
        logic [1:0]      len;
        logic [1:0]      pm;
        logic [1:0]      fac;
        logic            s1;
        logic            s2;
        logic [DW-1:0]   hold;
        logic            valid;
        logic            perr;
        logic            ferr;
        logic            brk;
        logic            ovr;
        logic            brk_end;
    } rx_t;

    rx_t q, d;
    logic           line;
    logic [CW-1:0]  bitc_q;
    logic [DBW-1:0] nbits_q;
    logic [DW-1:0]  got;
    logic           done, f_err, p_err, is_brk;

    always_comb begin
        d         = q;
        d.s1      = rxd;
        d.s2      = q.s1;
        d.brk_end = 1'b0;
        line      = q.s2;
        bitc_q    = bit_cycles(q.fac);
        nbits_q   = data_bits(q.len);
        got       = q.sh >> (2'd3 - q.len);
        done      = (q.st == RX_STOP) && (q.cnt == '0);
        f_err     = !line;
        is_brk    = f_err && (got == '0) && !(has_parity(q.pm) && q.pbit);
        p_err     = has_parity(q.pm) && (q.pbit != (q.pacc ^ (q.pm == PAR_ODD))) && !is_brk;

        if (rx_take) begin
            d.valid = 1'b0;
            d.ovr   = 1'b0;
        end

        case (q.st)
            RX_IDLE: begin
                if (!line) begin
                    d.len  = cfg_len;
                    d.pm   = cfg_par;
                    d.fac  = cfg_fac;
                    d.idx  = '0;
                    d.sh   = '0;
                    d.pacc = 1'b0;
                    d.pbit = 1'b0;
                    if (cfg_fac == 2'd0) begin
                        d.st  = RX_DATA;
                        d.cnt = '0;
                    end else begin
                        d.st  = RX_START;
                        d.cnt = (bit_cycles(cfg_fac) >> 1) - CW'(1);
                    end
                end
            end
            RX_START: begin
                if (q.cnt == '0) begin
                    if (line) begin
                        d.st = RX_IDLE;
                    end else begin
                        d.st  = RX_DATA;
                        d.cnt = bitc_q - CW'(1);
                    end
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            RX_DATA: begin
                if (q.cnt == '0) begin
                    d.sh   = {line, q.sh[DW-1:1]};
                    d.pacc = q.pacc ^ line;
                    d.cnt  = bitc_q - CW'(1);
                    if (q.idx == nbits_q - DBW'(1)) begin
                        d.st = has_parity(q.pm) ? RX_PAR : RX_STOP;
                    end else begin
                        d.idx = q.idx + DBW'(1);
                    end
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            RX_PAR: begin
                if (q.cnt == '0) begin
                    d.pbit = line;
                    d.st   = RX_STOP;
                    d.cnt  = bitc_q - CW'(1);
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            RX_STOP: begin
                if (q.cnt == '0) begin
                    d.st = is_brk ? RX_BRKW : RX_IDLE;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            RX_BRKW: begin
                if (line) begin
                    d.brk_end = 1'b1;
                    d.st      = RX_IDLE;
                end
            end
            default: d.st = RX_IDLE;
        endcase

        if (done) begin
            if (q.valid && !rx_take) begin
                d.ovr = 1'b1;
            end else begin
                d.valid = 1'b1;
                d.hold  = got;
                d.perr  = p_err;
                d.ferr  = f_err;
                d.brk   = is_brk;
                d.ovr   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data    = q.hold;
    assign rx_valid   = q.valid;
    assign rx_perr    = q.perr;
    assign rx_ferr    = q.ferr;
    assign rx_ovr     = q.ovr;
    assign rx_brk     = q.brk;
    assign rx_brk_end = q.brk_end;
endmodule

// File: rtl/serial_async_xcvr.sv
`timescale 1ns/1ps
module serial_async_xcvr
    import sax_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_stop,
    input  logic [1:0]    cfg_par,
    input  logic [1:0]    cfg_fac,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic          tx_break,
    output logic          txd,
    input  logic          rxd,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_take,
    output logic          rx_perr,
    output logic          rx_ferr,
    output logic          rx_ovr,
    output logic          rx_brk,
    output logic          rx_brk_end
);
    sax_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .cfg_len  (cfg_len),
        .cfg_stop (cfg_stop),
        .cfg_par  (cfg_par),
        .cfg_fac  (cfg_fac),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_break (tx_break),
        .txd      (txd)
    );

    sax_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .cfg_len    (cfg_len),
        .cfg_par    (cfg_par),
        .cfg_fac    (cfg_fac),
        .rxd        (rxd),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_take    (rx_take),
        .rx_perr    (rx_perr),
        .rx_ferr    (rx_ferr),
        .rx_ovr     (rx_ovr),
        .rx_brk     (rx_brk),
        .rx_brk_end (rx_brk_end)
    );
endmodule

// File: rtl/sax_checker.sv
`timescale 1ns/1ps
module sax_checker
    import sax_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_break,
    input logic          txd,
    input logic          rx_valid,
    input logic          rx_take,
    input logic [DW-1:0] rx_data,
    input logic          rx_ferr,
    input logic          rx_brk,
    input logic          rx_brk_end
);
    // R6: a commanded break drives the line to space on the next edge
    assert_break_forces_space_R6: assert property (@(posedge clk) disable iff (rst)
        tx_break |=> !txd);

    // R5: an accepted byte makes the transmitter busy
    assert_accept_goes_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R7, R12: the held character survives until taken, even across an overrun
    assert_hold_until_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_take) |=> (rx_valid && $stable(rx_data)));

    // R11: a break character is an all-zero framing error
    assert_break_char_flags_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_brk) |-> (rx_ferr && rx_data == '0));

    // R11: break end is a single-cycle pulse
    assert_brk_end_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rx_brk_end |=> !rx_brk_end);
endmodule

bind serial_async_xcvr sax_checker u_sax_checker (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_break   (tx_break),
    .txd        (txd),
    .rx_valid   (rx_valid),
    .rx_take    (rx_take),
    .rx_data    (rx_data),
    .rx_ferr    (rx_ferr),
    .rx_brk     (rx_brk),
    .rx_brk_end (rx_brk_end)
);

// File: tb/tb_serial_async_xcvr.sv
`timescale 1ns/1ps
module tb_serial_async_xcvr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0, cfg_par = 2'd0, cfg_fac = 2'd1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0, tx_break = 1'b0, rx_take = 1'b0;
    logic       loop = 1'b1, drv = 1'b1;
    logic       tx_ready, txd, rxd;
    logic [7:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr, rx_ovr, rx_brk, rx_brk_end;
    int         n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;
    assign rxd = loop ? txd : drv;

    serial_async_xcvr dut (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_stop(cfg_stop),
        .cfg_par(cfg_par), .cfg_fac(cfg_fac), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_break(tx_break),
        .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_take(rx_take), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_ovr(rx_ovr), .rx_brk(rx_brk), .rx_brk_end(rx_brk_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int fac_cycles(input logic [1:0] f);
        return (f == 2'd0) ? 1 : (16 << (f - 1));
    endfunction

    function automatic int rx_word();
        return {rx_valid, rx_perr, rx_ferr, rx_ovr, rx_brk, rx_data};
    endfunction

    task automatic take();
        rx_take = 1'b1;
        @(negedge clk);
        rx_take = 1'b0;
    endtask

    // loopback frame: checks txd every cycle, ready timing, and the received character
    task automatic send_check(input logic [7:0] data);
        int F, nb, hp, stc, fbits, total, mism;
        logic [11:0] fb;
        logic [7:0]  m;
        logic        e;
        F   = fac_cycles(cfg_fac);
        nb  = 5 + int'(cfg_len);
        hp  = (cfg_par == 2'd1 || cfg_par == 2'd2) ? 1 : 0;
        stc = (cfg_stop == 2'd0) ? F : (cfg_stop == 2'd1 ? ((F == 1) ? 2 : F + F / 2) : 2 * F);
        m   = 8'hFF >> (8 - nb);
        fb  = '0;
        for (int j = 0; j < nb; j++) fb[1 + j] = data[j];
        if (hp == 1) fb[1 + nb] = (^(data & m)) ^ (cfg_par == 2'd2);
        fbits = 1 + nb + hp;
        total = fbits * F + stc;
        while (!tx_ready) @(negedge clk);
        tx_data  = data;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        mism = 0;
        for (int i = 0; i < total; i++) begin
            e = (i < fbits * F) ? fb[i / F] : 1'b1;
            if (txd !== e || tx_ready !== 1'b0) mism++;
            @(negedge clk);
        end
        chk(mism == 0, "R2,R3 frame waveform", mism, 0);
        chk(txd === 1'b1 && tx_ready === 1'b1, "R4,R5 ready exactly after stop",
            int'({txd, tx_ready}), 3);
        repeat (6) @(negedge clk);
        chk(rx_word() == int'({5'b10000, data & m}), "R1,R7 loopback character",
            rx_word(), int'({5'b10000, data & m}));
        take();
    endtask

    // bench-driven frame, 8 data bits, 16x
    task automatic drive_frame(input logic [7:0] data, input logic pbit, input logic sbit);
        logic [10:0] v;
        v = {sbit, pbit, data, 1'b0};
        for (int j = 0; j < 11; j++) begin
            drv = v[j];
            repeat (16) @(negedge clk);
        end
        drv = 1'b1;
        repeat (32) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt, mism, k;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(txd === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0 && rx_brk_end === 1'b0,
            "R13 reset state", int'({txd, tx_ready, rx_valid, rx_brk_end}), 12);

        // sweep 1x and 16x over every length, stop and parity setting
        k = 0;
        for (int f = 0; f < 2; f++)
            for (int l = 0; l < 4; l++)
                for (int s = 0; s < 3; s++)
                    for (int p = 0; p < 3; p++) begin
                        cfg_fac = 2'(f); cfg_len = 2'(l); cfg_stop = 2'(s); cfg_par = 2'(p);
                        send_check(8'h5A + 8'(k * 37));
                        send_check(~(8'h5A + 8'(k * 37)));
                        k++;
                    end
        // 32x and 64x with eight data bits
        for (int f = 2; f < 4; f++)
            for (int s = 0; s < 3; s++)
                for (int p = 0; p < 3; p++) begin
                    cfg_fac = 2'(f); cfg_len = 2'd3; cfg_stop = 2'(s); cfg_par = 2'(p);
                    send_check(8'hC3 ^ 8'(s * 16 + p));
                end

        // directed receive cases: 8 data, even parity, 16x
        loop = 1'b0;
        cfg_fac = 2'd1; cfg_len = 2'd3; cfg_stop = 2'd0; cfg_par = 2'd1;
        repeat (4) @(negedge clk);

        // R8 glitch shorter than half a bit
        drv = 1'b0;
        repeat (5) @(negedge clk);
        drv = 1'b1;
        repeat (40) @(negedge clk);
        chk(rx_valid === 1'b0, "R8 glitch rejected", int'(rx_valid), 0);
        drive_frame(8'h96, 1'b0, 1'b1);
        chk(rx_word() == int'({5'b10000, 8'h96}), "R8 recovery after glitch",
            rx_word(), int'({5'b10000, 8'h96}));
        take();

        // R9 wrong parity bit
        drive_frame(8'h0F, 1'b1, 1'b1);
        chk(rx_word() == int'({5'b11000, 8'h0F}), "R9 parity error",
            rx_word(), int'({5'b11000, 8'h0F}));
        take();

        // R10 stop bit low, nonzero data
        drive_frame(8'h3C, 1'b0, 1'b0);
        chk(rx_word() == int'({5'b10100, 8'h3C}), "R10 framing error",
            rx_word(), int'({5'b10100, 8'h3C}));
        take();

        // R12 overrun keeps the older character
        drive_frame(8'h11, 1'b0, 1'b1);
        drive_frame(8'h22, 1'b0, 1'b1);
        chk(rx_word() == int'({5'b10010, 8'h11}), "R12 overrun keeps first",
            rx_word(), int'({5'b10010, 8'h11}));
        take();
        chk(rx_valid === 1'b0 && rx_ovr === 1'b0, "R12 take clears overrun",
            int'({rx_valid, rx_ovr}), 0);

        // R11 received break
        drv = 1'b0;
        repeat (250) @(negedge clk);
        chk(rx_word() == int'({5'b10101, 8'h00}), "R11 break character",
            rx_word(), int'({5'b10101, 8'h00}));
        take();
        drv = 1'b1;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            if (rx_brk_end === 1'b1) cnt++;
            @(negedge clk);
        end
        chk(cnt == 1, "R11 break end single pulse", cnt, 1);
        chk(rx_valid === 1'b0, "R11 no character during break", int'(rx_valid), 0);

        // R6 transmitted break aborts a character in flight
        loop = 1'b1;
        cfg_fac = 2'd1; cfg_len = 2'd3; cfg_stop = 2'd0; cfg_par = 2'd0;
        repeat (4) @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (30) @(negedge clk);
        tx_break = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0 && tx_ready === 1'b0, "R6 break takes the line",
            int'({txd, tx_ready}), 0);
        mism = 0;
        for (int i = 0; i < 200; i++) begin
            if (txd !== 1'b0 || tx_ready !== 1'b0) mism++;
            @(negedge clk);
        end
        chk(mism == 0, "R6 line held at space", mism, 0);
        chk(rx_word() == int'({5'b10101, 8'h00}), "R11 loopback break seen",
            rx_word(), int'({5'b10101, 8'h00}));
        take();
        tx_break = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1 && tx_ready === 1'b1, "R6 release restores mark",
            int'({txd, tx_ready}), 3);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            if (rx_brk_end === 1'b1) cnt++;
            @(negedge clk);
        end
        chk(cnt == 1, "R11 loopback break end", cnt, 1);

        // link still works after the break
        send_check(8'hE7);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule